// File: doc/BRIEF.md
# Return stack with shadow restore

This block is the hardware call/return stack of a small 8-bit microcontroller core. It holds return addresses pushed by call logic. It decodes the single-word return instruction and pops the newest address onto a 21-bit program counter output. Under one opcode bit, it also hands back saved copies of the working register, the status register and the bank select register. Those copies come from a one-deep shadow set that is loaded whenever a capture strobe fires, such as on a call or on interrupt entry.

Each instruction cycle spans four clocks, Q1 to Q4, and the block exposes its own phase count. Requests are sampled on the clock edge that ends Q1 and take effect on the edge that ends Q4. A return therefore takes two instruction cycles. The first decodes the word and pops the stack. The second is a dead cycle in which any instruction word is ignored. Stack overflow and underflow raise sticky flags but do not stop the core.

Top module: `ret_stack`

## Requirements
- R1: After reset, `pc_o`, `w_o`, `status_o` and `bsr_o` are 0, the stack is empty, and `pc_ld_o`, `rst_vld_o`, `ovf_o` and `unf_o` are all low.
- R2: A word is a return only when `instr_vld_i` is high at the end of Q1 and bits 15..1 of the word equal 000000000001001 (0x0012 or 0x0013). Any other word, or a return word with `instr_vld_i` low, produces no `pc_ld_o` pulse and leaves `pc_o` unchanged.
- R3: A return loads `pc_o` with the most recently pushed address that has not yet been popped, so addresses come back in LIFO order. In the same step, `pc_ld_o` pulses for exactly one clock, during Q1 of the following instruction cycle.
- R4: When bit 0 of the return word is 1, `w_o`, `status_o` and `bsr_o` take the shadow values at the time of the pop, and `rst_vld_o` pulses together with `pc_ld_o`.
- R5: When bit 0 of the return word is 0, `w_o`, `status_o` and `bsr_o` keep their values and `rst_vld_o` stays low.
- R6: The instruction cycle that follows a return is a dead cycle. A return word presented in it is not executed.
- R7: A clock edge with `shd_cap_i` high copies `w_i`, `status_i` and `bsr_i` into the shadow set, replacing any earlier copy.
- R8: A return on an empty stack loads 0 into `pc_o` and sets `unf_o`, which stays set until reset.
- R9: The stack holds 31 entries. A push when 31 entries are stored sets `ovf_o`, which stays set until reset, and leaves all stored entries unchanged.
- R10: When a return and a push are requested in the same instruction cycle, the return executes and the push is dropped.
- R11: `push_i` high at the end of Q1 stores `push_addr_i` on the stack at the end of Q4.
- R12: `phase_o` counts 0,1,2,3 (Q1..Q4) on successive clocks and wraps from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; four clocks per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word, sampled at end of Q1 |
| instr_vld_i | input | 1 | Instruction word valid |
| push_i | input | 1 | Push request, sampled at end of Q1 |
| push_addr_i | input | 21 | Return address to push |
| shd_cap_i | input | 1 | Shadow capture strobe |
| w_i | input | 8 | Live working register value to capture |
| status_i | input | 8 | Live status register value to capture |
| bsr_i | input | 8 | Live bank select value to capture |
| phase_o | output | 2 | Current phase, 0..3 for Q1..Q4 |
| pc_o | output | 21 | Program counter loaded by the last return |
| pc_ld_o | output | 1 | One-clock pulse: `pc_o` was just loaded |
| rst_vld_o | output | 1 | One-clock pulse: register outputs were just restored |
| w_o | output | 8 | Restored working register |
| status_o | output | 8 | Restored status register |
| bsr_o | output | 8 | Restored bank select register |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The stack pointer and the stored entries cannot be seen directly. A wrong pointer or a corrupted entry shows up only at the next return, when `pc_o` takes a value out of LIFO order. It can also show up as a flag set one entry early or late. For that reason the bench fills the stack to the limit and drains it completely, and each pop exposes one entry within one instruction cycle. A stale shadow or a wrong decode of the s bit shows on the register outputs in Q1 right after the pop. A dead cycle that fails to block a return shows as an extra `pc_ld_o` pulse four clocks later.

// File: rtl/ret_pkg.sv
package ret_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // upper fifteen bits of the return opcode; bit 0 selects shadow restore
    localparam logic [14:0] RET_OPC_HI = 15'h0009;

    typedef struct packed {
        logic [7:0] w;
        logic [7:0] st;
        logic [7:0] bsr;
    } shd_t;
endpackage

// File: rtl/ret_phase.sv
module ret_phase
    import ret_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);
    phase_e ph_d, ph_q;

    always_comb begin
        ph_d = phase_e'(ph_q + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= ph_d;
    end

    assign phase_o = ph_q;
endmodule

// File: rtl/ret_decode.sv
module ret_decode
    import ret_pkg::*;
(
    input  logic [15:0] instr_i,
    input  logic        vld_i,
    output logic        is_ret_o,
    output logic        s_bit_o
);
    always_comb begin
        is_ret_o = vld_i && (instr_i[15:1] == RET_OPC_HI);
        s_bit_o  = instr_i[0];
    end
endmodule

// File: rtl/ret_shadow.sv
module ret_shadow
    import ret_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  shd_t       live_i,
    output shd_t       shd_o
);
    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (cap_i) shd_d = live_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign shd_o = shd_q;
endmodule

// File: rtl/ret_lifo.sv
module ret_lifo #(
    parameter int DEPTH = 31,
    parameter int AW    = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en_i,
    input  logic          pop_en_i,
    input  logic [AW-1:0] push_data_i,
    output logic [AW-1:0] top_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int SPW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic           ovf;
        logic           unf;
    } lifo_t;

    lifo_t          st_d, st_q;
    logic           do_wr;
    logic [AW-1:0]  mem_q [DEPTH];
    logic [DEPTH-1:0] wr_en;

    always_comb begin
        st_d  = st_q;
        do_wr = 1'b0;
        if (pop_en_i) begin
            if (st_q.sp == '0) st_d.unf = 1'b1;
            else               st_d.sp  = st_q.sp - SPW'(1);
        end else if (push_en_i) begin
            if (st_q.sp == SPW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                do_wr   = 1'b1;
                st_d.sp = st_q.sp + SPW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one register per entry, written only at the current pointer
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign wr_en[g] = do_wr && (st_q.sp == SPW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)        mem_q[g] <= '0;
            else if (wr_en[g]) mem_q[g] <= push_data_i;
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.sp == SPW'(i + 1)) top_o = mem_q[i];
        end
    end

    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int AW    = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   instr_i,
    input  logic          instr_vld_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          shd_cap_i,
    input  logic [7:0]    w_i,
    input  logic [7:0]    status_i,
    input  logic [7:0]    bsr_i,
    output logic [1:0]    phase_o,
    output logic [AW-1:0] pc_o,
    output logic          pc_ld_o,
    output logic          rst_vld_o,
    output logic [7:0]    w_o,
    output logic [7:0]    status_o,
    output logic [7:0]    bsr_o,
    output logic          ovf_o,
    output logic          unf_o
);
    typedef struct packed {
        logic          ret_pend;
        logic          s_bit;
        logic          push_pend;
        logic [AW-1:0] push_addr;
        logic          busy;
        logic [AW-1:0] pc;
        logic          pc_ld;
        logic          rst_vld;
        shd_t          regs;
    } ctl_t;

    ctl_t          c_d, c_q;
    phase_e        phase;
    logic          is_ret, s_bit;
    logic          pop_en, push_en;
    logic [AW-1:0] top;
    shd_t          shd;

    ret_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    ret_decode u_dec (
        .instr_i  (instr_i),
        .vld_i    (instr_vld_i),
        .is_ret_o (is_ret),
        .s_bit_o  (s_bit)
    );

    ret_shadow u_shd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (shd_cap_i),
        .live_i ('{w: w_i, st: status_i, bsr: bsr_i}),
        .shd_o  (shd)
    );

    ret_lifo #(.DEPTH(DEPTH), .AW(AW)) u_lifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en_i   (push_en),
        .pop_en_i    (pop_en),
        .push_data_i (c_q.push_addr),
        .top_o       (top),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    always_comb begin
        c_d         = c_q;
        c_d.pc_ld   = 1'b0;
        c_d.rst_vld = 1'b0;
        pop_en      = 1'b0;
        push_en     = 1'b0;
        unique case (phase)
            PH_Q1: begin
                c_d.ret_pend  = is_ret && !c_q.busy;
                c_d.s_bit     = s_bit;
                c_d.push_pend = push_i;
                c_d.push_addr = push_addr_i;
            end
            PH_Q4: begin
                if (c_q.ret_pend) begin
                    pop_en    = 1'b1;
                    c_d.pc    = top;
                    c_d.pc_ld = 1'b1;
                    if (c_q.s_bit) begin
                        c_d.regs    = shd;
                        c_d.rst_vld = 1'b1;
                    end
                    c_d.busy = 1'b1;
                end else begin
                    push_en  = c_q.push_pend;
                    c_d.busy = 1'b0;
                end
                c_d.ret_pend  = 1'b0;
                c_d.push_pend = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign phase_o   = phase;
    assign pc_o      = c_q.pc;
    assign pc_ld_o   = c_q.pc_ld;
    assign rst_vld_o = c_q.rst_vld;
    assign w_o       = c_q.regs.w;
    assign status_o  = c_q.regs.st;
    assign bsr_o     = c_q.regs.bsr;
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int AW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    phase_o,
    input logic [AW-1:0] pc_o,
    input logic          pc_ld_o,
    input logic          rst_vld_o,
    input logic [7:0]    w_o,
    input logic [7:0]    status_o,
    input logic [7:0]    bsr_o,
    input logic          ovf_o,
    input logic          unf_o
);
    p_ld_in_q1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_o |-> phase_o == 2'd0);
    p_ld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_o |=> !pc_ld_o);
    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_ld_o |-> $stable(pc_o));
    p_restore_with_ld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_vld_o |-> pc_ld_o);
    p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_vld_o |-> $stable({w_o, status_o, bsr_o}));
    p_unf_pc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_o) |-> (pc_ld_o && pc_o == '0));
    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    p_phase_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd3 |=> phase_o == 2'd0);
endmodule

bind ret_stack ret_stack_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (phase_o),
    .pc_o      (pc_o),
    .pc_ld_o   (pc_ld_o),
    .rst_vld_o (rst_vld_o),
    .w_o       (w_o),
    .status_o  (status_o),
    .bsr_o     (bsr_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
);

// File: tb/ret_stack_tb.sv
module ret_stack_tb;
    localparam int DEPTH = 31;
    localparam int AW    = 21;
    localparam logic [15:0] RET0 = 16'h0012;
    localparam logic [15:0] RET1 = 16'h0013;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   instr_i = '0;
    logic          instr_vld_i = 1'b0;
    logic          push_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic          shd_cap_i = 1'b0;
    logic [7:0]    w_i = '0, status_i = '0, bsr_i = '0;
    logic [1:0]    phase_o;
    logic [AW-1:0] pc_o;
    logic          pc_ld_o, rst_vld_o, ovf_o, unf_o;
    logic [7:0]    w_o, status_o, bsr_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_dut (.*);

    function automatic logic [AW-1:0] addr_of(input int i);
        return AW'(i * 32'h0ABCD + 32'h111);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one instruction cycle: drive at Q1, return at Q1 of the next cycle
    task automatic cyc(input logic [15:0] iw, input logic iv, input logic pu,
                       input logic [AW-1:0] pa, input logic cap,
                       input logic [7:0] cw, input logic [7:0] cs, input logic [7:0] cb);
        instr_i = iw; instr_vld_i = iv; push_i = pu; push_addr_i = pa;
        shd_cap_i = cap; w_i = cw; status_i = cs; bsr_i = cb;
        @(negedge clk);
        instr_vld_i = 1'b0; push_i = 1'b0; shd_cap_i = 1'b0; instr_i = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic nop();      cyc('0, 0, 0, '0, 0, 0, 0, 0); endtask
    task automatic push(input logic [AW-1:0] a); cyc('0, 0, 1, a, 0, 0, 0, 0); endtask
    task automatic ret(input logic s); cyc(s ? RET1 : RET0, 1, 0, '0, 0, 0, 0, 0); endtask
    task automatic cap(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        cyc('0, 0, 0, '0, 1, a, b, c);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(pc_o == '0 && !pc_ld_o && !rst_vld_o, "R1 pc/pulses", pc_o, 0);
        chk(!ovf_o && !unf_o, "R1 flags", {ovf_o, unf_o}, 0);
        chk({w_o, status_o, bsr_o} == '0, "R1 regs", {w_o, status_o, bsr_o}, 0);
        // R12 phase count
        for (int k = 0; k < 8; k++) begin
            chk(phase_o == 2'(k), "R12 phase", phase_o, 2'(k));
            @(negedge clk);
        end
        // R11 pushes, R2 non-return words leave pc alone
        push(21'h0A001); push(21'h0B002); push(21'h0C003);
        for (int b = 1; b < 16; b++) begin
            cyc(RET0 ^ 16'(1 << b), 1, 0, '0, 0, 0, 0, 0);
            chk(!pc_ld_o && pc_o == '0, "R2 non-return word", {pc_ld_o, pc_o}, 0);
        end
        cyc(RET1, 0, 0, '0, 0, 0, 0, 0);
        chk(!pc_ld_o, "R2 return word without valid", pc_ld_o, 0);
        // R7 capture, R5 s=0 return
        cap(8'h5A, 8'h1F, 8'h03);
        ret(1'b0);
        chk(pc_ld_o && pc_o == 21'h0C003, "R3 R11 LIFO top", pc_o, 21'h0C003);
        chk(!rst_vld_o && {w_o, status_o, bsr_o} == '0, "R5 s=0 keeps regs", {rst_vld_o, w_o, status_o, bsr_o}, 0);
        // R6 return word in dead cycle ignored
        ret(1'b1);
        chk(!pc_ld_o && !rst_vld_o && pc_o == 21'h0C003, "R6 dead cycle", {pc_ld_o, pc_o}, 21'h0C003);
        // R4 s=1 restore
        ret(1'b1);
        chk(pc_ld_o && pc_o == 21'h0B002, "R3 second pop", pc_o, 21'h0B002);
        chk(rst_vld_o && {w_o, status_o, bsr_o} == 24'h5A1F03, "R4 restore", {w_o, status_o, bsr_o}, 24'h5A1F03);
        nop();
        // R7 later capture replaces earlier
        cap(8'hA5, 8'hE0, 8'h0F);
        ret(1'b1);
        chk(pc_o == 21'h0A001 && {w_o, status_o, bsr_o} == 24'hA5E00F, "R7 new shadow", {w_o, status_o, bsr_o}, 24'hA5E00F);
        nop();
        // R8 empty pop
        chk(!unf_o, "R8 no underflow yet", unf_o, 0);
        ret(1'b0);
        chk(pc_ld_o && pc_o == '0 && unf_o, "R8 underflow", {unf_o, pc_o}, 32'h200000);
        nop();
        // R10 push dropped when a return shares the cycle
        push(21'h1ABCD);
        cyc(RET0, 1, 1, 21'h12345, 0, 0, 0, 0);
        chk(pc_o == 21'h1ABCD, "R10 return wins", pc_o, 21'h1ABCD);
        nop();
        ret(1'b0);
        chk(pc_ld_o && pc_o == '0, "R10 dropped push not stored", pc_o, 0);
        nop();
        chk(unf_o, "R8 flag sticky", unf_o, 1);
        // R9 fill, overflow, drain
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(addr_of(i));
        chk(!ovf_o, "R9 full without overflow", ovf_o, 0);
        push(21'h1FFFFF);
        chk(ovf_o, "R9 overflow set", ovf_o, 1);
        for (int k = 0; k < DEPTH; k++) begin
            ret(1'b0);
            chk(pc_ld_o && pc_o == addr_of(DEPTH - 1 - k), "R9 R3 drain order", pc_o, addr_of(DEPTH - 1 - k));
            nop();
        end
        chk(!unf_o && ovf_o, "R9 R8 flags after drain", {ovf_o, unf_o}, 2);
        ret(1'b0);
        chk(unf_o && pc_o == '0, "R8 pop past bottom", {unf_o, pc_o}, 32'h200000);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule